// File: doc/BRIEF.md
# Vectored Interrupt Controller With Stack Gating

This block is the interrupt controller of a small 8-bit microcontroller core. Five sources feed it: a falling edge on an external pin, overflow pulses from two timer/event counters, a real-time-clock event and a dialer I/O event. Each source owns an enable bit and a request flag. Together with one global enable, these sit in two 8-bit control registers that the core reads and writes over a simple register port.

When the global enable is set, at least one enabled source is pending and the call stack is not full, the block raises a request and presents a fixed vector address. The core then pushes only its program counter and jumps to that address. It pulses the acknowledge input in the same cycle. On that acknowledge the block clears the global enable and the flag of the source it chose. Other sources go on recording flags, but none is taken until software sets the global enable again. A separate wake output brings the core out of halt whenever an enabled source is pending, whatever the global enable or the stack state.

Top module: `vec_irq_ctrl`

## Requirements
- R1: The external pin passes through a two-flop synchronizer. A high-to-low transition sets the external flag on the third rising clock edge after the pin changes. A rising edge or a pin held low sets nothing.
- R2: A one-cycle pulse on `tmr0_ovf_i`, `tmr1_ovf_i`, `rtc_evt_i` or `dial_evt_i` sets that source's flag on the next clock edge.
- R3: `irq_req_o` is 1 only when the global enable is 1, `stack_full_i` is 0 and some source has both its enable and its flag set.
- R4: `irq_vec_o` is 0x04 for external, 0x08 for timer 0, 0x0C for timer 1, 0x10 for RTC and 0x14 for dialer. It is 0 when no request is raised.
- R5: When several sources are eligible, the fixed priority is external, timer 0, timer 1, RTC, dialer (highest first).
- R6: Register address 0x0B holds, from bit 0 to bit 6: global enable, external enable, timer 0 enable, timer 1 enable, external flag, timer 0 flag, timer 1 flag. Bit 7 reads 0.
- R7: Register address 0x1E holds the RTC enable in bit 1, the dialer enable in bit 2, the RTC flag in bit 5 and the dialer flag in bit 6. Bits 0, 3, 4 and 7 read 0 and ignore writes. Any other address reads 0, and writes to it change nothing.
- R8: A cycle with `irq_ack_i` and `irq_req_o` both 1 clears the global enable and the flag of the chosen source. Other flags keep their values, and new events still set flags while the global enable is 0.
- R9: Software writes set or clear flag bits directly. A hardware event in the same cycle as a software clear leaves the flag set.
- R10: `wake_o` is 1 whenever some source has both its enable and its flag set, independent of the global enable and of `stack_full_i`.
- R11: After reset, both registers read 0, and `irq_req_o` and `wake_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| tmr0_ovf_i | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf_i | input | 1 | Timer 1 overflow pulse |
| rtc_evt_i | input | 1 | Real-time clock event pulse |
| dial_evt_i | input | 1 | Dialer I/O event pulse |
| stack_full_i | input | 1 | Call stack is full |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_req_o | output | 1 | Interrupt request to core |
| irq_vec_o | output | 8 | Vector address of chosen source |
| irq_ack_i | input | 1 | Core takes the request this cycle |
| wake_o | output | 1 | Wake core from halt |

## Verification
Two functions can fall in the same cycle on one flag: a hardware event setting it and a software write or an acknowledge clearing it. The bench raises a timer overflow pulse in exactly the cycle in which a register write clears that flag. It then reads the register back and expects the flag to be set. The acknowledge path is judged the same way: the global enable must read 0 afterwards, and a flag raised by a different source while the global enable is 0 must remain pending.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int unsigned NSRC     = 5;
  localparam int unsigned DW       = 8;
  localparam int unsigned AW       = 8;
  localparam int unsigned VEC_BASE = 4;
  localparam int unsigned VEC_STEP = 4;
  localparam logic [AW-1:0] ADDR_CTL0 = 8'h0B;
  localparam logic [AW-1:0] ADDR_CTL1 = 8'h1E;

  typedef enum logic [2:0] {
    SRC_EXT  = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_TMR1 = 3'd2,
    SRC_RTC  = 3'd3,
    SRC_DIAL = 3'd4
  } src_e;
endpackage

// File: rtl/vec_irq_fall_det.sv
module vec_irq_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  localparam int unsigned W = STAGES + 1;
  logic [W-1:0] sh_q;

  // idle-high reset so no edge is seen right after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[W-2:0], pin_i};
  end

  assign fall_o = sh_q[W-1] & ~sh_q[W-2];
endmodule

// File: rtl/vec_irq_flag_cell.sv
module vec_irq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_set_i,
  input  logic ack_clr_i,
  input  logic sw_we_i,
  input  logic sw_val_i,
  output logic flag_o
);
  logic flag_q;

  // hw set > ack clear > sw write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (hw_set_i)  flag_q <= 1'b1;
    else if (ack_clr_i) flag_q <= 1'b0;
    else if (sw_we_i)   flag_q <= sw_val_i;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/vec_irq_prio_pick.sv
module vec_irq_prio_pick #(
  parameter int unsigned N        = 5,
  parameter int unsigned VW       = 8,
  parameter int unsigned VEC_BASE = 4,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic [N-1:0]  cand_i,
  output logic          any_o,
  output logic [N-1:0]  grant_o,
  output logic [VW-1:0] vec_o
);
  always_comb begin
    grant_o = '0;
    vec_o   = '0;
    // walk from lowest priority up so index 0 wins last
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        grant_o = '0;
        grant_o[i] = 1'b1;
        vec_o = VW'(VEC_BASE + VEC_STEP * i);
      end
    end
  end

  assign any_o = |cand_i;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_pin_i,
  input  logic          tmr0_ovf_i,
  input  logic          tmr1_ovf_i,
  input  logic          rtc_evt_i,
  input  logic          dial_evt_i,
  input  logic          stack_full_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_req_o,
  output logic [DW-1:0] irq_vec_o,
  input  logic          irq_ack_i,
  output logic          wake_o
);
  logic            gie_q;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] hw_set;
  logic [NSRC-1:0] sw_we;
  logic [NSRC-1:0] sw_val;
  logic [NSRC-1:0] en_we;
  logic [NSRC-1:0] en_val;
  logic [NSRC-1:0] grant;
  logic [NSRC-1:0] cand;
  logic            any_cand;
  logic            ext_fall;
  logic            we0, we1, take;
  logic [DW-1:0]   pick_vec;

  assign we0 = reg_we_i && (reg_addr_i == ADDR_CTL0);
  assign we1 = reg_we_i && (reg_addr_i == ADDR_CTL1);

  vec_irq_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .fall_o (ext_fall)
  );

  assign hw_set = {dial_evt_i, rtc_evt_i, tmr1_ovf_i, tmr0_ovf_i, ext_fall};

  // register bit map per source
  always_comb begin
    sw_we  = '0; sw_val = '0;
    en_we  = '0; en_val = '0;
    for (int i = 0; i < 3; i++) begin
      en_we[i]  = we0;
      en_val[i] = reg_wdata_i[1+i];
      sw_we[i]  = we0;
      sw_val[i] = reg_wdata_i[4+i];
    end
    for (int i = 3; i < NSRC; i++) begin
      en_we[i]  = we1;
      en_val[i] = reg_wdata_i[i-2];
      sw_we[i]  = we1;
      sw_val[i] = reg_wdata_i[i+2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0;
      en_q  <= '0;
    end else begin
      if (take)     gie_q <= 1'b0;
      else if (we0) gie_q <= reg_wdata_i[0];
      for (int i = 0; i < NSRC; i++)
        if (en_we[i]) en_q[i] <= en_val[i];
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    vec_irq_flag_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hw_set_i  (hw_set[g]),
      .ack_clr_i (take & grant[g]),
      .sw_we_i   (sw_we[g]),
      .sw_val_i  (sw_val[g]),
      .flag_o    (flag_q[g])
    );
  end

  assign cand = en_q & flag_q;

  vec_irq_prio_pick #(
    .N(NSRC), .VW(DW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_pick (
    .cand_i  (cand),
    .any_o   (any_cand),
    .grant_o (grant),
    .vec_o   (pick_vec)
  );

  assign irq_req_o = gie_q & ~stack_full_i & any_cand;
  assign irq_vec_o = irq_req_o ? pick_vec : '0;
  assign take      = irq_ack_i & irq_req_o;
  assign wake_o    = any_cand;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTL0: reg_rdata_o = {1'b0, flag_q[2:0], en_q[2:0], gie_q};
      ADDR_CTL1: reg_rdata_o = {1'b0, flag_q[4:3], 2'b00, en_q[4:3], 1'b0};
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stack_full_i,
  input logic       tmr0_ovf_i,
  input logic       irq_ack_i,
  input logic       irq_req_o,
  input logic [7:0] irq_vec_o,
  input logic [7:0] reg_rdata_o,
  input logic       wake_o,
  input logic       gie_q,
  input logic [4:0] flag_q
);
  AST_STACK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_full_i |-> !irq_req_o); // R3
  AST_GIE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q |-> !irq_req_o); // R3
  AST_VEC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_vec_o[1:0] == 2'b00 && irq_vec_o >= 8'h04 && irq_vec_o <= 8'h14)); // R4
  AST_ACK_DROPS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_req_o) |=> !gie_q); // R8
  AST_TMR0_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr0_ovf_i |=> flag_q[1]); // R2
  AST_REQ_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> wake_o); // R10
  AST_TOP_BIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[7]); // R6
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stack_full_i (stack_full_i),
  .tmr0_ovf_i   (tmr0_ovf_i),
  .irq_ack_i    (irq_ack_i),
  .irq_req_o    (irq_req_o),
  .irq_vec_o    (irq_vec_o),
  .reg_rdata_o  (reg_rdata_o),
  .wake_o       (wake_o),
  .gie_q        (gie_q),
  .flag_q       (flag_q)
);

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_pin_i = 1'b1;
  logic       tmr0_ovf_i = 1'b0, tmr1_ovf_i = 1'b0, rtc_evt_i = 1'b0, dial_evt_i = 1'b0;
  logic       stack_full_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_addr_i = 8'h00, reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o, irq_vec_o;
  logic       irq_req_o, irq_ack_i = 1'b0, wake_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  vec_irq_ctrl dut_i (.*);

  // {ctl0, ctl1, stack_full, exp_req, exp_vec, exp_wake}
  localparam int NV = 12;
  localparam logic [26:0] TBL [NV] = '{
    {8'h13, 8'h00, 1'b0, 1'b1, 8'h04, 1'b1},
    {8'h13, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1},
    {8'h12, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1},
    {8'h11, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0},
    {8'h7F, 8'h66, 1'b0, 1'b1, 8'h04, 1'b1},
    {8'h6D, 8'h00, 1'b0, 1'b1, 8'h08, 1'b1},
    {8'h49, 8'h00, 1'b0, 1'b1, 8'h0C, 1'b1},
    {8'h01, 8'h22, 1'b0, 1'b1, 8'h10, 1'b1},
    {8'h01, 8'h44, 1'b0, 1'b1, 8'h14, 1'b1},
    {8'h01, 8'h66, 1'b0, 1'b1, 8'h10, 1'b1},
    {8'h41, 8'h44, 1'b0, 1'b1, 8'h14, 1'b1},
    {8'h20, 8'h44, 1'b0, 1'b0, 8'h00, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
  endtask

  task automatic ack_pulse();
    @(negedge clk_i); irq_ack_i = 1'b1;
    @(negedge clk_i); irq_ack_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R11 reset state
    rd(8'h0B, d); chk("R11 ctl0", d, 8'h00);
    rd(8'h1E, d); chk("R11 ctl1", d, 8'h00);
    chk("R11 req", {7'b0, irq_req_o}, 8'h00);
    chk("R11 wake", {7'b0, wake_o}, 8'h00);

    // table walk: R3 R4 R5 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      stack_full_i = TBL[i][18];
      wr(8'h0B, TBL[i][26:19]);
      wr(8'h1E, TBL[i][18:11] & 8'h00 | TBL[i][18:11]);
      wr(8'h1E, TBL[i][18:11]);
      stack_full_i = TBL[i][10];
      #0.5;
      chk($sformatf("R3 req row%0d", i), {7'b0, irq_req_o}, {7'b0, TBL[i][9]});
      if (TBL[i][9]) chk($sformatf("R4 R5 vec row%0d", i), irq_vec_o, TBL[i][8:1]);
      chk($sformatf("R10 wake row%0d", i), {7'b0, wake_o}, {7'b0, TBL[i][0]});
      rd(8'h0B, d); chk($sformatf("R6 ctl0 row%0d", i), d, TBL[i][26:19]);
      rd(8'h1E, d); chk($sformatf("R7 ctl1 row%0d", i), d, TBL[i][18:11]);
    end
    stack_full_i = 1'b0;
    wr(8'h0B, 8'h00); wr(8'h1E, 8'h00);

    // R7 reserved bits and unmapped address
    wr(8'h1E, 8'hFF);
    rd(8'h1E, d); chk("R7 reserved", d, 8'h66);
    wr(8'h20, 8'hFF);
    rd(8'h20, d); chk("R7 unmapped read", d, 8'h00);
    rd(8'h0B, d); chk("R7 unmapped write", d, 8'h00);
    wr(8'h1E, 8'h00);

    // R1 external falling edge through synchronizer
    wr(8'h0B, 8'h03);
    @(negedge clk_i); ext_pin_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    rd(8'h0B, d); chk("R1 not yet after 2 edges", d, 8'h03);
    @(negedge clk_i);
    rd(8'h0B, d); chk("R1 flag after 3 edges", d, 8'h13);
    chk("R1 vec", irq_vec_o, 8'h04);
    wr(8'h0B, 8'h03);
    repeat (5) @(negedge clk_i);
    rd(8'h0B, d); chk("R1 held low no retrigger", d, 8'h03);
    ext_pin_i = 1'b1;
    repeat (5) @(negedge clk_i);
    rd(8'h0B, d); chk("R1 rising edge ignored", d, 8'h03);

    // R2 event pulses
    wr(8'h0B, 8'h00);
    @(negedge clk_i); tmr1_ovf_i = 1'b1; rtc_evt_i = 1'b1;
    @(negedge clk_i); tmr1_ovf_i = 1'b0; rtc_evt_i = 1'b0; dial_evt_i = 1'b1;
    @(negedge clk_i); dial_evt_i = 1'b0;
    rd(8'h0B, d); chk("R2 tmr1 flag", d, 8'h40);
    rd(8'h1E, d); chk("R2 rtc dial flags", d, 8'h60);
    @(negedge clk_i); tmr0_ovf_i = 1'b1;
    @(negedge clk_i); tmr0_ovf_i = 1'b0;
    rd(8'h0B, d); chk("R2 tmr0 flag", d, 8'h60);
    wr(8'h0B, 8'h00); wr(8'h1E, 8'h00);

    // R8 acknowledge
    wr(8'h0B, 8'h37);
    #0.5; chk("R8 pre vec", irq_vec_o, 8'h04);
    ack_pulse();
    rd(8'h0B, d); chk("R8 gie and ext flag cleared", d, 8'h26);
    chk("R8 no req after ack", {7'b0, irq_req_o}, 8'h00);
    @(negedge clk_i); tmr1_ovf_i = 1'b1;
    @(negedge clk_i); tmr1_ovf_i = 1'b0;
    rd(8'h0B, d); chk("R8 flag recorded while gie 0", d, 8'h66);
    wr(8'h0B, 8'h67);
    #0.5; chk("R8 re-enable vec", irq_vec_o, 8'h08);

    // R9 hardware set beats software clear
    wr(8'h0B, 8'h00);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 8'h0B; reg_wdata_i = 8'h00; tmr0_ovf_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; tmr0_ovf_i = 1'b0;
    rd(8'h0B, d); chk("R9 set wins over clear", d, 8'h20);
    wr(8'h0B, 8'h00);
    rd(8'h0B, d); chk("R9 software clear", d, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule